// File: doc/BRIEF.md
# Monitor Mode Entry Controller

This block settles, at the moment the power-on reset is released, whether the chip boots into its serial monitor mode or into normal execution. Two things qualify. The first is a high-voltage indication on the interrupt pin, called the pin path. The second is an erased reset vector, where both vector bytes read 0xFF, called the blank path. The decision is latched once and then held until the next power-on reset.

The latched result sets the bus clock enable. This enable fires on every oscillator cycle when the divider is bypassed, and on every other cycle otherwise. On the blank path the block also stretches the internal reset by a fixed number of bus cycles. In monitor mode it then drives a break character onto the serial transmit line: ten bit times at zero, each bit time being 256 bus cycles. After the break it pulses a ready flag that starts the command interpreter.

Top module: `mon_entry_ctrl`

## Requirements
- R1: The entry decision is taken at the first oscillator edge after `por_n_i` rises. Later changes on `hv_irq_i`, `clk_sel_i`, `vec_hi_i` or `vec_lo_i` change neither `mon_mode_o` nor the bus clock enable pattern.
- R2: With `hv_irq_i` high at release (pin path), `mon_mode_o` goes to 1. With `clk_sel_i` low, `bus_en_o` is 1 on every cycle. With `clk_sel_i` high, `bus_en_o` alternates 1, 0, 1, 0.
- R3: With `hv_irq_i` low and both vector bytes equal to 8'hFF (blank path), `mon_mode_o` goes to 1 and `bus_en_o` alternates whatever level `clk_sel_i` has.
- R4: When both conditions hold, the pin path wins: there is no extended reset, and `clk_sel_i` selects the divide ratio as in R2.
- R5: When neither condition holds, `mon_mode_o` stays 0, `bus_en_o` alternates, `tx_o` stays 1 and `ready_o` never rises.
- R6: On the blank path, `int_rst_o` stays 1 for exactly 16 sampled cycles in which `bus_en_o` is 1. On the other paths, `int_rst_o` is 0 from the first edge after release.
- R7: `mon_mode_o` holds its latched value through the extended reset and is cleared only by `por_n_i` low.
- R8: In monitor mode, once `int_rst_o` is 0, `tx_o` is driven to 0 for exactly 10 × 256 cycles in which `bus_en_o` is 1. `tx_o` stays 1 while `int_rst_o` is 1.
- R9: At the end of the break, `tx_o` returns to 1 and `ready_o` is 1 for exactly one oscillator cycle, in the same cycle that `tx_o` first reads 1. Both then stay idle.
- R10: While `por_n_i` is 0: `mon_mode_o`=0, `int_rst_o`=1, `tx_o`=1, `ready_o`=0, `bus_en_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Raw oscillator clock |
| por_n_i | input | 1 | Power-on reset, active low, asynchronous assert |
| hv_irq_i | input | 1 | High-voltage detected on interrupt pin |
| clk_sel_i | input | 1 | Divider select pin (low bypasses divide-by-two on pin path) |
| vec_hi_i | input | 8 | Reset vector high byte from nonvolatile memory |
| vec_lo_i | input | 8 | Reset vector low byte from nonvolatile memory |
| mon_mode_o | output | 1 | Latched monitor mode flag |
| bus_en_o | output | 1 | Bus clock enable (divide by one or two) |
| int_rst_o | output | 1 | Internal reset, stretched on blank path |
| tx_o | output | 1 | Serial transmit line, idle high |
| ready_o | output | 1 | One-cycle start pulse for the command interpreter |

## Verification
A wrong latched decision shows at once: `mon_mode_o` and the `bus_en_o` pattern are wrong from the first sample after release. Any drift after the pins are scrambled shows within two cycles. A miscounted reset stretch or bit counter does not show until the end of that phase. It then appears as a wrong count of enabled cycles under `int_rst_o` or under a low `tx_o`, so the break length is checked to the exact enabled cycle. A stuck break sequencer shows up as a missing or repeated `ready_o` pulse, or a pulse that is not aligned with the rise of `tx_o`.

// File: rtl/mon_entry_pkg.sv
package mon_entry_pkg;

  typedef struct packed {
    logic mon;      // monitor mode entered
    logic ext_rst;  // blank-vector path: stretch internal reset
    logic div1;     // divider bypassed
  } entry_t;

  typedef enum logic [1:0] {RS_WAIT, RS_EXT, RS_DONE} rst_st_e;
  typedef enum logic [1:0] {BK_IDLE, BK_LOW, BK_DONE} brk_st_e;

  // Entry decision; the pin path has priority over the blank path.
  function automatic entry_t decide_entry(input logic hv, input logic sel,
                                          input logic [7:0] hi, input logic [7:0] lo);
    entry_t e;
    logic blank;
    blank     = (hi == 8'hFF) && (lo == 8'hFF);
    e.mon     = hv || blank;
    e.ext_rst = !hv && blank;
    e.div1    = hv && !sel;
    return e;
  endfunction

  function automatic int unsigned break_cycles(input int unsigned bits,
                                               input int unsigned bit_cyc);
    return bits * bit_cyc;
  endfunction

endpackage

// File: rtl/mon_entry_latch.sv
module mon_entry_latch
  import mon_entry_pkg::*;
(
  input  logic       clk,
  input  logic       por_n,
  input  logic       hv,
  input  logic       sel,
  input  logic [7:0] vec_hi,
  input  logic [7:0] vec_lo,
  output logic       latch_now,
  output logic       take_ext,
  output logic       decided,
  output logic       mon,
  output logic       ext_path,
  output logic       div1
);
  entry_t dec_w;
  entry_t held_q;
  logic   decided_q;

  always_comb dec_w = decide_entry(hv, sel, vec_hi, vec_lo);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      decided_q <= 1'b0;
      held_q    <= '0;
    end else if (!decided_q) begin
      decided_q <= 1'b1;
      held_q    <= dec_w;
    end
  end

  assign latch_now = !decided_q;
  assign take_ext  = dec_w.ext_rst;
  assign decided   = decided_q;
  assign mon       = held_q.mon;
  assign ext_path  = held_q.ext_rst;
  assign div1      = held_q.div1;
endmodule

// File: rtl/mon_clk_div.sv
module mon_clk_div (
  input  logic clk,
  input  logic por_n,
  input  logic div1,
  output logic bus_en
);
  logic ph_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) ph_q <= 1'b0;
    else        ph_q <= !ph_q;
  end

  assign bus_en = div1 || ph_q;
endmodule

// File: rtl/mon_rst_stretch.sv
module mon_rst_stretch
  import mon_entry_pkg::*;
#(
  parameter int unsigned XRST_CYCLES = 16
) (
  input  logic clk,
  input  logic por_n,
  input  logic latch_now,
  input  logic take_ext,
  input  logic bus_en,
  output logic int_rst
);
  localparam int unsigned XW = (XRST_CYCLES > 1) ? $clog2(XRST_CYCLES) : 1;
  localparam logic [XW-1:0] XLAST = XW'(XRST_CYCLES - 1);

  rst_st_e        st_q;
  logic [XW-1:0]  cnt_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      st_q  <= RS_WAIT;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        RS_WAIT: if (latch_now) begin
          st_q  <= take_ext ? RS_EXT : RS_DONE;
          cnt_q <= '0;
        end
        RS_EXT: if (bus_en) begin
          if (cnt_q == XLAST) st_q <= RS_DONE;
          else                cnt_q <= cnt_q + 1'b1;
        end
        default: st_q <= RS_DONE;
      endcase
    end
  end

  assign int_rst = (st_q != RS_DONE);
endmodule

// File: rtl/mon_break_tx.sv
module mon_break_tx
  import mon_entry_pkg::*;
#(
  parameter int unsigned BIT_CYCLES = 256,
  parameter int unsigned BREAK_BITS = 10
) (
  input  logic clk,
  input  logic por_n,
  input  logic mon,
  input  logic int_rst,
  input  logic bus_en,
  output logic tx,
  output logic ready,
  output logic brk_active,
  output logic bit_tick
);
  localparam int unsigned CW = (BIT_CYCLES > 1) ? $clog2(BIT_CYCLES) : 1;
  localparam int unsigned BW = (BREAK_BITS > 1) ? $clog2(BREAK_BITS) : 1;
  localparam logic [CW-1:0] CLAST = CW'(BIT_CYCLES - 1);
  localparam logic [BW-1:0] BLAST = BW'(BREAK_BITS - 1);

  brk_st_e       st_q;
  logic [CW-1:0] cyc_q;
  logic [BW-1:0] bit_q;
  logic          tx_q;
  logic          ready_q;
  logic          last_w;

  assign bit_tick = (st_q == BK_LOW) && bus_en && (cyc_q == CLAST);
  assign last_w   = bit_tick && (bit_q == BLAST);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      st_q    <= BK_IDLE;
      cyc_q   <= '0;
      bit_q   <= '0;
      tx_q    <= 1'b1;
      ready_q <= 1'b0;
    end else begin
      ready_q <= last_w;
      unique case (st_q)
        BK_IDLE: if (mon && !int_rst) begin
          st_q  <= BK_LOW;
          tx_q  <= 1'b0;
          cyc_q <= '0;
          bit_q <= '0;
        end
        BK_LOW: if (bus_en) begin
          if (cyc_q == CLAST) begin
            cyc_q <= '0;
            if (bit_q == BLAST) begin
              st_q <= BK_DONE;
              tx_q <= 1'b1;
            end else begin
              bit_q <= bit_q + 1'b1;
            end
          end else begin
            cyc_q <= cyc_q + 1'b1;
          end
        end
        default: tx_q <= 1'b1;
      endcase
    end
  end

  assign tx         = tx_q;
  assign ready      = ready_q;
  assign brk_active = (st_q == BK_LOW);
endmodule

// File: rtl/mon_entry_ctrl.sv
module mon_entry_ctrl
  import mon_entry_pkg::*;
#(
  parameter int unsigned BIT_CYCLES  = 256,
  parameter int unsigned BREAK_BITS  = 10,
  parameter int unsigned XRST_CYCLES = 16
) (
  input  logic       clk_i,
  input  logic       por_n_i,
  input  logic       hv_irq_i,
  input  logic       clk_sel_i,
  input  logic [7:0] vec_hi_i,
  input  logic [7:0] vec_lo_i,
  output logic       mon_mode_o,
  output logic       bus_en_o,
  output logic       int_rst_o,
  output logic       tx_o,
  output logic       ready_o
);
  logic latch_now_w, take_ext_w, decided_w, mon_w, ext_path_w, div1_w;
  logic bus_en_w, int_rst_w, brk_active_w, bit_tick_w;

  mon_entry_latch u_latch (
    .clk(clk_i), .por_n(por_n_i), .hv(hv_irq_i), .sel(clk_sel_i),
    .vec_hi(vec_hi_i), .vec_lo(vec_lo_i),
    .latch_now(latch_now_w), .take_ext(take_ext_w), .decided(decided_w),
    .mon(mon_w), .ext_path(ext_path_w), .div1(div1_w)
  );

  mon_clk_div u_div (
    .clk(clk_i), .por_n(por_n_i), .div1(div1_w), .bus_en(bus_en_w)
  );

  mon_rst_stretch #(.XRST_CYCLES(XRST_CYCLES)) u_rst (
    .clk(clk_i), .por_n(por_n_i), .latch_now(latch_now_w),
    .take_ext(take_ext_w), .bus_en(bus_en_w), .int_rst(int_rst_w)
  );

  mon_break_tx #(.BIT_CYCLES(BIT_CYCLES), .BREAK_BITS(BREAK_BITS)) u_brk (
    .clk(clk_i), .por_n(por_n_i), .mon(mon_w), .int_rst(int_rst_w),
    .bus_en(bus_en_w), .tx(tx_o), .ready(ready_o),
    .brk_active(brk_active_w), .bit_tick(bit_tick_w)
  );

  assign mon_mode_o = mon_w;
  assign bus_en_o   = bus_en_w;
  assign int_rst_o  = int_rst_w;
endmodule

// File: rtl/mon_entry_chk.sv
module mon_entry_chk #(
  parameter int unsigned BREAK_BITS = 10
) (
  input logic clk,
  input logic por_n,
  input logic decided,
  input logic mon,
  input logic ext_path,
  input logic div1,
  input logic bus_en,
  input logic int_rst,
  input logic tx,
  input logic ready,
  input logic brk_active,
  input logic bit_tick
);
  localparam int unsigned TW = $clog2(BREAK_BITS + 1) + 1;
  logic [TW-1:0] tick_cnt_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)        tick_cnt_q <= '0;
    else if (bit_tick) tick_cnt_q <= tick_cnt_q + 1'b1;
  end

  p_mode_stable_r1: assert property (@(posedge clk) disable iff (!por_n)
    decided |=> $stable(mon));
  p_div_stable_r1: assert property (@(posedge clk) disable iff (!por_n)
    decided |=> $stable(div1));
  p_full_rate_r2: assert property (@(posedge clk) disable iff (!por_n)
    div1 |-> bus_en);
  p_half_rate_r3: assert property (@(posedge clk) disable iff (!por_n)
    (decided && !div1) |=> (bus_en != $past(bus_en)));
  p_blank_div2_r3: assert property (@(posedge clk) disable iff (!por_n)
    ext_path |-> !div1);
  p_idle_nomon_r5: assert property (@(posedge clk) disable iff (!por_n)
    (decided && !mon) |-> (tx && !ready && !brk_active));
  p_short_rst_r6: assert property (@(posedge clk) disable iff (!por_n)
    (decided && !ext_path) |-> !int_rst);
  p_mode_in_ext_r7: assert property (@(posedge clk) disable iff (!por_n)
    (decided && int_rst) |-> mon);
  p_tx_high_rst_r8: assert property (@(posedge clk) disable iff (!por_n)
    int_rst |-> tx);
  p_bit_bound_r8: assert property (@(posedge clk) disable iff (!por_n)
    tick_cnt_q <= TW'(BREAK_BITS));
  p_ready_pulse_r9: assert property (@(posedge clk) disable iff (!por_n)
    ready |=> !ready);
  p_ready_tx_r9: assert property (@(posedge clk) disable iff (!por_n)
    ready |-> (tx && !brk_active));
endmodule

bind mon_entry_ctrl mon_entry_chk #(.BREAK_BITS(BREAK_BITS)) u_chk (
  .clk(clk_i), .por_n(por_n_i), .decided(decided_w), .mon(mon_w),
  .ext_path(ext_path_w), .div1(div1_w), .bus_en(bus_en_w),
  .int_rst(int_rst_w), .tx(tx_o), .ready(ready_o),
  .brk_active(brk_active_w), .bit_tick(bit_tick_w)
);

// File: tb/test_mon_entry_ctrl.sv
module test_mon_entry_ctrl;
  localparam int BITC = 256;
  localparam int BITS = 10;
  localparam int XRST = 16;

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic hv = 1'b0, sel = 1'b0;
  logic [7:0] vh = 8'h00, vl = 8'h00;
  logic mon_mode, bus_en, int_rst, tx, ready;
  int tests = 0, fails = 0;

  always #5 clk = ~clk;

  mon_entry_ctrl #(.BIT_CYCLES(BITC), .BREAK_BITS(BITS), .XRST_CYCLES(XRST)) i_mon_entry_ctrl (
    .clk_i(clk), .por_n_i(por_n), .hv_irq_i(hv), .clk_sel_i(sel),
    .vec_hi_i(vh), .vec_lo_i(vl), .mon_mode_o(mon_mode), .bus_en_o(bus_en),
    .int_rst_o(int_rst), .tx_o(tx), .ready_o(ready)
  );

  // {monitor, stretched reset, full rate}
  function automatic logic [2:0] expect_entry(logic h, logic s, logic [7:0] a, logic [7:0] b);
    logic erased;
    erased = &{a, b};
    if (h)      return {1'b1, 1'b0, ~s};
    if (erased) return 3'b110;
    return 3'b000;
  endfunction

  task automatic check(input logic ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_case(input logic a_hv, input logic a_sel,
                          input logic [7:0] a_hi, input logic [7:0] a_lo, input logic prio);
    logic [2:0] e;
    int mon_bad = 0, bus_bad = 0, rst_bus = 0, lo_bus = 0, rdy_n = 0;
    int rdy_bad = 0, tail = 0, limit;
    logic first_rst = 1'b1, prev_bus = 1'b0, prev_tx = 1'b1, low_seen = 1'b0;
    e = expect_entry(a_hv, a_sel, a_hi, a_lo);
    por_n = 1'b0;
    hv = a_hv; sel = a_sel; vh = a_hi; vl = a_lo;
    repeat (4) @(negedge clk);
    // R10: reset state
    check(!mon_mode && int_rst && tx && !ready && !bus_en, "R10 reset state",
          {mon_mode, int_rst, tx, ready, bus_en}, 5'b01100);
    por_n = 1'b1;
    limit = e[2] ? 6000 : 400;
    for (int n = 1; n <= limit; n++) begin
      @(negedge clk);
      if (n == 1) first_rst = int_rst;
      if (mon_mode !== e[2]) mon_bad++;
      if (e[0] && !bus_en) bus_bad++;
      if (!e[0] && n > 1 && bus_en == prev_bus) bus_bad++;
      if (int_rst && bus_en) rst_bus++;
      if (!tx && bus_en) lo_bus++;
      if (!tx) low_seen = 1'b1;
      if (ready) begin
        rdy_n++;
        if (!(tx && !prev_tx)) rdy_bad++;
      end
      prev_bus = bus_en;
      prev_tx  = tx;
      // R1: scramble the entry pins after the decision
      hv = 1'($urandom); sel = 1'($urandom);
      vh = ($urandom % 2) ? 8'hFF : 8'($urandom);
      vl = ($urandom % 2) ? 8'hFF : 8'($urandom);
      if (rdy_n > 0) begin
        tail++;
        if (tail >= 20) break;
      end
    end
    check(mon_bad == 0, "R1/R7 latched mode held", mon_bad, 0);
    check(bus_bad == 0, e[0] ? "R2 full-rate enable" : (e[1] ? "R3 half-rate enable" : "R2/R5 half-rate enable"),
          bus_bad, 0);
    if (e[1]) check(rst_bus == XRST, "R6 stretched reset length", rst_bus, XRST);
    else      check(first_rst == 1'b0, "R6 reset released at first edge", first_rst, 0);
    if (prio) check(first_rst == 1'b0 && e[2], "R4 pin path priority", first_rst, 0);
    if (e[2]) begin
      check(lo_bus == BITS * BITC, "R8 break length", lo_bus, BITS * BITC);
      check(rdy_n == 1, "R9 single ready pulse", rdy_n, 1);
      check(rdy_bad == 0 && tx, "R9 ready aligned with tx rise", rdy_bad, 0);
    end else begin
      check(!low_seen && rdy_n == 0, "R5 idle line without monitor", rdy_n + int'(low_seen), 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    run_case(1'b1, 1'b0, 8'h12, 8'h34, 1'b0); // R2 divider bypassed
    run_case(1'b1, 1'b1, 8'h00, 8'h80, 1'b0); // R2 divider kept
    run_case(1'b0, 1'b0, 8'hFF, 8'hFF, 1'b0); // R3 blank, select low ignored
    run_case(1'b0, 1'b1, 8'hFF, 8'hFF, 1'b0); // R3 blank, select high
    run_case(1'b1, 1'b0, 8'hFF, 8'hFF, 1'b1); // R4 both, bypass
    run_case(1'b1, 1'b1, 8'hFF, 8'hFF, 1'b1); // R4 both, divide
    run_case(1'b0, 1'b0, 8'hFF, 8'hFE, 1'b0); // R5 one byte programmed
    run_case(1'b0, 1'b1, 8'h7F, 8'hFF, 1'b0); // R5
    for (int k = 0; k < 4; k++) begin
      logic rh, rs;
      logic [7:0] ra, rb;
      rh = 1'($urandom); rs = 1'($urandom);
      ra = ($urandom % 2) ? 8'hFF : 8'($urandom);
      rb = ($urandom % 2) ? 8'hFF : 8'($urandom);
      run_case(rh, rs, ra, rb, 1'b0);
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule